// File: doc/BRIEF.md
# Configurable Multilevel Pipeline Register

This block is a bank of four data registers fed from one shared data input. A 2-bit operation code, applied with each rising clock edge, sets how data moves through the bank. The bank can act as a single four-deep shift pipeline. It can also act as two independent two-deep pipelines, called lane A and lane B, each loaded on its own. The operation code can change on any cycle, so the same storage switches between these two arrangements while it runs.

A 2-bit read select chooses one of the four registers for the output port. An active-low output enable lets the output share a bus by releasing it to high impedance. Both the select and the enable act without a clock.

A build-time parameter sets what a lane load does to that lane's second stage. With push-through, the old first-stage value moves down into the second stage. With overwrite, the second stage is left alone and changes only during a four-deep shift.

Top module: `mlpr_pipe_reg`

## Requirements
- R1: While `rst_n` is low, all four registers are cleared to zero.
- R2: Operation 2'b00 shifts the whole bank on a rising edge: A1 takes `din`, A2 takes A1, B1 takes A2, and B2 takes B1.
- R3: Operation 2'b11 holds the bank, and all four registers keep their values across the edge.
- R4: Operation 2'b10 loads `din` into A1, and B1 and B2 stay unchanged.
- R5: Operation 2'b01 loads `din` into B1, and A1 and A2 stay unchanged.
- R6: When `PUSH_THROUGH` = 1, a lane load (2'b10 or 2'b01) moves the lane's old first-stage value into its second stage.
- R7: When `PUSH_THROUGH` = 0, a lane load leaves the lane's second stage unchanged, and only operation 2'b00 can then change it.
- R8: Read select values 0, 1, 2 and 3 place A1, A2, B1 and B2 on `q`. The output follows a change of select with no clock edge.
- R9: When `oe_n` is high, `q` is all high-impedance. When `oe_n` is low, `q` is driven with the selected register, and this too needs no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all register updates |
| rst_n | input | 1 | Asynchronous active-low clear of the bank |
| op | input | 2 | Operation code: 00 shift four-deep, 01 load lane B, 10 load lane A, 11 hold |
| din | input | WIDTH | Shared data input |
| rd_sel | input | 2 | Read select: 0 A1, 1 A2, 2 B1, 3 B2 |
| oe_n | input | 1 | Active-low output enable |
| q | output | WIDTH | Three-state data output |

## Verification
The bench builds two copies with the default 8-bit width: one with `PUSH_THROUGH` = 1 and one with `PUSH_THROUGH` = 0. Both copies receive the same stimulus, so every lane load shows side by side how the second stage is pushed in one copy and kept in the other. It also shows that only the four-deep shift reaches the kept stage in the overwrite copy. All four registers are read through every select value after each operation, so any mistake in the chain ordering or the lane split shows up at the port.

// File: rtl/mlpr_pkg.sv
package mlpr_pkg;

   localparam int unsigned NUM_REGS = 4;

   typedef enum logic [1:0] {
      OP_SHIFT4 = 2'b00,
      OP_LOAD_B = 2'b01,
      OP_LOAD_A = 2'b10,
      OP_HOLD   = 2'b11
   } op_t;

   // register slots: lane A first stage, lane A second, lane B first, lane B second
   localparam int unsigned SLOT_A1 = 0;
   localparam int unsigned SLOT_A2 = 1;
   localparam int unsigned SLOT_B1 = 2;
   localparam int unsigned SLOT_B2 = 3;

endpackage

// File: rtl/mlpr_ctrl.sv
module mlpr_ctrl
   import mlpr_pkg::*;
#(
   parameter bit PUSH_THROUGH = 1'b1
) (
   input  op_t                 op,
   output logic [NUM_REGS-1:0] load_en,
   output logic                b1_from_chain
);

   logic second_follows;

   generate
      if (PUSH_THROUGH) begin : g_push
         assign second_follows = 1'b1;
      end else begin : g_over
         assign second_follows = 1'b0;
      end
   endgenerate

   always_comb begin
      load_en       = '0;
      b1_from_chain = 1'b0;
      unique case (op)
         OP_SHIFT4: begin
            load_en       = '1;
            b1_from_chain = 1'b1;
         end
         OP_LOAD_A: begin
            load_en[SLOT_A1] = 1'b1;
            load_en[SLOT_A2] = second_follows;
         end
         OP_LOAD_B: begin
            load_en[SLOT_B1] = 1'b1;
            load_en[SLOT_B2] = second_follows;
         end
         default: load_en = '0;
      endcase
   end

endmodule

// File: rtl/mlpr_bank.sv
module mlpr_bank
   import mlpr_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [WIDTH-1:0]               din,
   input  logic [NUM_REGS-1:0]            load_en,
   input  logic                           b1_from_chain,
   output logic [NUM_REGS-1:0][WIDTH-1:0] regs
);

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
         logic [WIDTH-1:0] src;
         if (i == SLOT_A1) begin : g_a1
            assign src = din;
         end else if (i == SLOT_B1) begin : g_b1
            assign src = b1_from_chain ? regs[SLOT_A2] : din;
         end else begin : g_second
            assign src = regs[i-1];
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          regs[i] <= '0;
            else if (load_en[i]) regs[i] <= src;
         end
      end
   endgenerate

endmodule

// File: rtl/mlpr_outmux.sv
module mlpr_outmux
   import mlpr_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic [NUM_REGS-1:0][WIDTH-1:0] regs,
   input  logic [1:0]                     rd_sel,
   input  logic                           oe_n,
   output logic [WIDTH-1:0]               q
);

   logic [NUM_REGS-1:0] pick;
   logic [WIDTH-1:0]    picked;

   always_comb begin
      picked = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         pick[i] = (rd_sel == i[1:0]);
         picked  = picked | (regs[i] & {WIDTH{pick[i]}});
      end
   end

   assign q = oe_n ? {WIDTH{1'bz}} : picked;

endmodule

// File: rtl/mlpr_pipe_reg.sv
module mlpr_pipe_reg
   import mlpr_pkg::*;
#(
   parameter int unsigned WIDTH        = 8,
   parameter bit          PUSH_THROUGH = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       op,
   input  logic [WIDTH-1:0] din,
   input  logic [1:0]       rd_sel,
   input  logic             oe_n,
   output logic [WIDTH-1:0] q
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("mlpr_pipe_reg: WIDTH must be at least 1");
      end
   endgenerate

   op_t                           op_e;
   logic [NUM_REGS-1:0]           load_en;
   logic                          b1_from_chain;
   logic [NUM_REGS-1:0][WIDTH-1:0] regs;

   assign op_e = op_t'(op);

   mlpr_ctrl #(.PUSH_THROUGH(PUSH_THROUGH)) u_ctrl (
      .op            (op_e),
      .load_en       (load_en),
      .b1_from_chain (b1_from_chain)
   );

   mlpr_bank #(.WIDTH(WIDTH)) u_bank (
      .clk           (clk),
      .rst_n         (rst_n),
      .din           (din),
      .load_en       (load_en),
      .b1_from_chain (b1_from_chain),
      .regs          (regs)
   );

   mlpr_outmux #(.WIDTH(WIDTH)) u_outmux (
      .regs   (regs),
      .rd_sel (rd_sel),
      .oe_n   (oe_n),
      .q      (q)
   );

   AST_HOLD_KEEPS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      op == OP_HOLD |=> $stable(regs)); // R3

   AST_SHIFT_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
      op == OP_SHIFT4 |=> (regs[SLOT_A1] == $past(din) && regs[SLOT_A2] == $past(regs[SLOT_A1])
                           && regs[SLOT_B1] == $past(regs[SLOT_A2]) && regs[SLOT_B2] == $past(regs[SLOT_B1]))); // R2

   AST_LOAD_A_SPARES_B: assert property (@(posedge clk) disable iff (!rst_n)
      op == OP_LOAD_A |=> (regs[SLOT_A1] == $past(din) && $stable(regs[SLOT_B1]) && $stable(regs[SLOT_B2]))); // R4

   AST_LOAD_B_SPARES_A: assert property (@(posedge clk) disable iff (!rst_n)
      op == OP_LOAD_B |=> (regs[SLOT_B1] == $past(din) && $stable(regs[SLOT_A1]) && $stable(regs[SLOT_A2]))); // R5

   generate
      if (PUSH_THROUGH) begin : g_chk_push
         AST_PUSH_SECOND_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
            op == OP_LOAD_A |=> regs[SLOT_A2] == $past(regs[SLOT_A1])); // R6
      end else begin : g_chk_over
         AST_KEEP_SECOND_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
            op == OP_LOAD_B |=> $stable(regs[SLOT_B2])); // R7
      end
   endgenerate

endmodule

// File: tb/tb_mlpr_pipe_reg.sv
module tb_mlpr_pipe_reg;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   op = 2'b11;
   logic [W-1:0] din = '0;
   logic [1:0]   rd_sel = 2'b00;
   logic         oe_n = 1'b0;
   logic [W-1:0] q_pt, q_ow;

   int checks = 0;
   int failures = 0;

   // bench-side expectation per requirement; index 0 A1, 1 A2, 2 B1, 3 B2
   logic [W-1:0] m_pt [4];
   logic [W-1:0] m_ow [4];

   always #10 clk = ~clk;

   mlpr_pipe_reg #(.WIDTH(W), .PUSH_THROUGH(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .op(op), .din(din), .rd_sel(rd_sel), .oe_n(oe_n), .q(q_pt));

   mlpr_pipe_reg #(.WIDTH(W), .PUSH_THROUGH(1'b0)) dut_ow (
      .clk(clk), .rst_n(rst_n), .op(op), .din(din), .rd_sel(rd_sel), .oe_n(oe_n), .q(q_ow));

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      for (int s = 0; s < 4; s++) begin
         rd_sel = s[1:0];
         #1;
         check({tag, " push"}, q_pt, m_pt[s]);
         check({tag, " over"}, q_ow, m_ow[s]);
      end
   endtask

   task automatic apply(input logic [1:0] o, input logic [W-1:0] d);
      @(negedge clk);
      op  = o;
      din = d;
      @(posedge clk);
      case (o)
         2'b00: begin
            m_pt[3] = m_pt[2]; m_pt[2] = m_pt[1]; m_pt[1] = m_pt[0]; m_pt[0] = d;
            m_ow[3] = m_ow[2]; m_ow[2] = m_ow[1]; m_ow[1] = m_ow[0]; m_ow[0] = d;
         end
         2'b10: begin
            m_pt[1] = m_pt[0]; m_pt[0] = d;
            m_ow[0] = d;
         end
         2'b01: begin
            m_pt[3] = m_pt[2]; m_pt[2] = d;
            m_ow[2] = d;
         end
         default: ;
      endcase
      #1;
   endtask

   task automatic test_reset;
      for (int i = 0; i < 4; i++) begin m_pt[i] = '0; m_ow[i] = '0; end
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #2;
      check_all("R1 reset clear");
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic test_shift;
      apply(2'b00, 8'h11); check_all("R2 shift 1");
      apply(2'b00, 8'h22); check_all("R2 shift 2");
      apply(2'b00, 8'h33);
      apply(2'b00, 8'h44); check_all("R2 shift full chain R8");
   endtask

   task automatic test_hold;
      apply(2'b11, 8'hEE); check_all("R3 hold");
      apply(2'b11, 8'h5A); check_all("R3 hold again");
   endtask

   task automatic test_load_a;
      apply(2'b10, 8'hA5); check_all("R4 R6 R7 load A");
      apply(2'b10, 8'hC3); check_all("R4 R6 R7 load A twice");
   endtask

   task automatic test_load_b;
      apply(2'b01, 8'h5B); check_all("R5 R6 R7 load B");
      apply(2'b01, 8'h7E); check_all("R5 R6 R7 load B twice");
   endtask

   task automatic test_second_via_shift;
      apply(2'b00, 8'h90); check_all("R7 second stage via shift");
      apply(2'b10, 8'h01);
      apply(2'b01, 8'h02); check_all("R7 lanes after mixed loads");
   endtask

   task automatic test_select_comb;
      @(negedge clk);
      op = 2'b11;
      #3;
      rd_sel = 2'b11; #1;
      check("R8 select B2 no clock push", q_pt, m_pt[3]);
      rd_sel = 2'b00; #1;
      check("R8 select A1 no clock push", q_pt, m_pt[0]);
      rd_sel = 2'b10; #1;
      check("R8 select B1 no clock over", q_ow, m_ow[2]);
   endtask

   task automatic test_oe;
      @(negedge clk);
      #3;
      rd_sel = 2'b01;
      oe_n = 1'b1; #1;
      check("R9 disabled push", q_pt, {W{1'bz}});
      check("R9 disabled over", q_ow, {W{1'bz}});
      oe_n = 1'b0; #1;
      check("R9 enabled push", q_pt, m_pt[1]);
      check("R9 enabled over", q_ow, m_ow[1]);
   endtask

   initial begin
      #(20 * 150000);
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      test_reset();
      test_shift();
      test_hold();
      test_load_a();
      test_load_b();
      test_second_via_shift();
      test_select_comb();
      test_oe();
      test_hold();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule